// File: doc/BRIEF.md
# Optical Disc Sector-Rate Sequencer

This block models the timing side of an optical-disc drive and its sector decoder. It does not move any sector data. It acts only on a sector tick, a one-clock strobe that arrives at the disc's sector rate of 75 per second. Each tick stands for one sector. On a tick the block retires a drive command that has finished, counts down the seek delay that must pass before sectors flow, steps the block address while scanning, and records whether the current track carries data or audio.

A controller sends play, pause, stop, fast-forward and fast-reverse strobes and supplies a target block address. It also supplies a per-track data/audio bit and an interrupt enable byte. The block returns the signed current block address, a one-clock sector-ready strobe, a status word, and two interrupt request pulses: one for drive events and one for decoder events. A play command issued while the drive is stopped or paused arms a seek delay of `PLAY_DELAY` ticks. Delays shorter than 6 ticks are too short to be safe. When decoder and drive requests fall on the same tick, the decoder request is raised first.

Top module: `cd_sector_sequencer`

## Requirements
- R1: With no sector tick and no command strobe on an edge, `cur_lba`, `status_word` and `sector_ready` keep their values.
- R2: `drive_cmd_done` sets a pending flag. On the next tick the flag clears and `status_word[2:0]` takes the drive mode code held before that edge: stop=0, pause=1, read=2, fast-forward=3, fast-reverse=4. If `irq_enable[4]` is set, `drive_irq` pulses for one clock.
- R3: A play command loads `cur_lba` with `target_lba` and enters read mode. It loads the seek delay with `PLAY_DELAY` when issued from stop or pause, and with zero when issued from read or either scan mode.
- R4: In read mode, a tick with a non-zero delay decrements the delay and delivers no sector.
- R5: In read mode, a tick with a zero delay delivers one sector. `sector_ready` pulses, `cur_lba` increases by 1, the 4-bit delivered count in `status_word[7:4]` increases by 1, and `decoder_irq` pulses if `irq_enable[5]` is set.
- R6: In fast-forward mode each tick adds `SCAN_STRIDE` to `cur_lba`.
- R7: In fast-reverse mode each tick subtracts `SCAN_STRIDE` from `cur_lba`, clamping at `LBA_FLOOR` (-150).
- R8: On each read-mode tick, `status_word[8]` takes `track_is_data`. In other modes it holds its value.
- R9: When a sector delivery and a drive retirement fall on the same tick, `decoder_irq` pulses on that edge and `drive_irq` pulses one clock later. The two never pulse together.
- R10: Pause and stop leave read mode, so later ticks deliver no sector and do not move `cur_lba`.
- R11: When several command strobes are high together, only one takes effect, in the priority order stop, pause, play, fast-forward, fast-reverse. A tick on the same edge as a command does no delivery, countdown or scan step.
- R12: After reset: `cur_lba` is 0, the mode is stop, `status_word` is 0, and `sector_ready`, `drive_irq` and `decoder_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_tick | input | 1 | One-clock sector-rate strobe |
| play_cmd | input | 1 | Play command strobe |
| pause_cmd | input | 1 | Pause command strobe |
| stop_cmd | input | 1 | Stop command strobe |
| ffwd_cmd | input | 1 | Fast-forward command strobe |
| frev_cmd | input | 1 | Fast-reverse command strobe |
| drive_cmd_done | input | 1 | Drive command completion strobe |
| target_lba | input | LBA_W | Signed play target block address |
| track_is_data | input | 1 | 1 when the current track is a data track |
| irq_enable | input | 8 | Interrupt enables: bit 4 drive, bit 5 decoder |
| cur_lba | output | LBA_W | Signed current block address |
| sector_ready | output | 1 | One-clock sector delivered strobe |
| status_word | output | 16 | [2:0] drive mode code at retirement, [7:4] delivered count, [8] data track |
| drive_irq | output | 1 | Drive interrupt request pulse |
| decoder_irq | output | 1 | Decoder interrupt request pulse |

## Verification
The bench builds the block with `PLAY_DELAY` set to 6, the smallest safe delay, and keeps the default stride of 10 and floor of -150. With the shorter delay, full seek countdowns fit beside long fast-reverse runs that reach the clamp. They also leave room for delivered-count wrap-around, same-tick interrupt ordering, simultaneous command strobes and a tick that lands on the same edge as a command.

// File: rtl/cdseq_pkg.sv
package cdseq_pkg;

    typedef enum logic [2:0] {
        MODE_STOP  = 3'd0,
        MODE_PAUSE = 3'd1,
        MODE_READ  = 3'd2,
        MODE_FFWD  = 3'd3,
        MODE_FREV  = 3'd4
    } drive_mode_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STOP,
        CMD_PAUSE,
        CMD_PLAY,
        CMD_FFWD,
        CMD_FREV
    } drive_cmd_e;

    localparam int DRV_IRQ_EN_BIT = 4;
    localparam int DEC_IRQ_EN_BIT = 5;

    // Strongest command wins: stop, pause, play, fast forward, fast reverse.
    function automatic drive_cmd_e pick_cmd(input logic stop_s, input logic pause_s,
                                            input logic play_s, input logic ffwd_s,
                                            input logic frev_s);
        if (stop_s)       return CMD_STOP;
        else if (pause_s) return CMD_PAUSE;
        else if (play_s)  return CMD_PLAY;
        else if (ffwd_s)  return CMD_FFWD;
        else if (frev_s)  return CMD_FREV;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/cdseq_delay.sv
module cdseq_delay #(
    parameter int PLAY_DELAY = 20,
    parameter int DELAY_W    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_full,
    input  logic load_zero,
    input  logic count_en,
    output logic is_zero
);

    typedef struct packed {
        logic [DELAY_W-1:0] cnt;
    } delay_state_t;

    delay_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_full)
            st_d.cnt = DELAY_W'(PLAY_DELAY);
        else if (load_zero)
            st_d.cnt = '0;
        else if (count_en && st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_zero = (st_q.cnt == '0);

    // R4: a counting tick lowers the delay by exactly one
    a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !load_full && !load_zero && !is_zero) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R3: an arming play leaves the full delay in place
    a_r3_arm_delay: assert property (@(posedge clk) disable iff (!rst_n)
        load_full |=> (st_q.cnt == DELAY_W'(PLAY_DELAY)));

endmodule

// File: rtl/cdseq_lba.sv
module cdseq_lba #(
    parameter int LBA_W       = 20,
    parameter int SCAN_STRIDE = 10,
    parameter int LBA_FLOOR   = -150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LBA_W-1:0] target,
    input  logic             inc_one,
    input  logic             step_fwd,
    input  logic             step_rev,
    output logic [LBA_W-1:0] lba
);

    localparam int WIDE_W = LBA_W + 1;
    localparam logic signed [WIDE_W-1:0] FLOOR_W  = WIDE_W'(LBA_FLOOR);
    localparam logic signed [WIDE_W-1:0] STRIDE_W = WIDE_W'(SCAN_STRIDE);

    typedef struct packed {
        logic [LBA_W-1:0] addr;
    } lba_state_t;

    lba_state_t st_d, st_q;
    logic signed [WIDE_W-1:0] wide_cur;
    logic signed [WIDE_W-1:0] wide_back;

    always_comb begin
        st_d      = st_q;
        wide_cur  = {st_q.addr[LBA_W-1], st_q.addr};
        wide_back = wide_cur - STRIDE_W;
        if (load)
            st_d.addr = target;
        else if (inc_one)
            st_d.addr = st_q.addr + 1'b1;
        else if (step_fwd)
            st_d.addr = st_q.addr + LBA_W'(SCAN_STRIDE);
        else if (step_rev) begin
            if (wide_back < FLOOR_W) st_d.addr = FLOOR_W[LBA_W-1:0];
            else                     st_d.addr = wide_back[LBA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lba = st_q.addr;

    // R6: forward scan moves by one stride
    a_r6_fwd_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fwd && !load && !inc_one) |=> (lba == $past(lba) + LBA_W'(SCAN_STRIDE)));

    // R7: reverse scan never lands below the floor
    a_r7_rev_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (step_rev && !load && !inc_one && !step_fwd) |=> ($signed({lba[LBA_W-1], lba}) >= FLOOR_W));

endmodule

// File: rtl/cdseq_irq.sv
module cdseq_irq
    import cdseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        cmd_done,
    input  logic        drv_en,
    input  logic        dec_fire,
    input  drive_mode_e mode_now,
    output logic        drive_irq,
    output logic        dec_irq,
    output logic [2:0]  drv_status
);

    typedef struct packed {
        logic        done;
        logic        defer;
        logic        drv;
        logic        dec;
        drive_mode_e stat;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic retire;
    logic fire;

    always_comb begin
        st_d   = st_q;
        retire = tick && st_q.done;
        fire   = retire && drv_en;
        st_d.done  = (st_q.done && !retire) || cmd_done;
        if (retire) st_d.stat = mode_now;
        st_d.dec   = dec_fire;
        // decoder first: a colliding drive request slips one clock
        st_d.drv   = st_q.defer || (fire && !dec_fire);
        st_d.defer = fire && dec_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{done: 1'b0, defer: 1'b0, drv: 1'b0, dec: 1'b0, stat: MODE_STOP};
        else        st_q <= st_d;
    end

    assign drive_irq  = st_q.drv;
    assign dec_irq    = st_q.dec;
    assign drv_status = st_q.stat;

    // R9: the two requests never pulse on the same clock
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_irq && dec_irq));

    // R9: a slipped drive request appears on the next clock
    a_r9_slip: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.defer |=> drive_irq);

    // R2: a retiring tick clears the pending flag
    a_r2_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.done && !cmd_done) |=> !st_q.done);

endmodule

// File: rtl/cd_sector_sequencer.sv
module cd_sector_sequencer
    import cdseq_pkg::*;
#(
    parameter int LBA_W       = 20,
    parameter int PLAY_DELAY  = 20,
    parameter int SCAN_STRIDE = 10,
    parameter int LBA_FLOOR   = -150,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sector_tick,
    input  logic             play_cmd,
    input  logic             pause_cmd,
    input  logic             stop_cmd,
    input  logic             ffwd_cmd,
    input  logic             frev_cmd,
    input  logic             drive_cmd_done,
    input  logic [LBA_W-1:0] target_lba,
    input  logic             track_is_data,
    input  logic [7:0]       irq_enable,
    output logic [LBA_W-1:0] cur_lba,
    output logic             sector_ready,
    output logic [15:0]      status_word,
    output logic             drive_irq,
    output logic             decoder_irq
);

    localparam int DELAY_W = $clog2(PLAY_DELAY + 1);

    typedef struct packed {
        drive_mode_e      mode;
        logic             data;
        logic [CNT_W-1:0] count;
        logic             ready;
    } top_state_t;

    top_state_t st_d, st_q;
    drive_cmd_e cmd;
    logic       idle_tick;
    logic       deliver;
    logic       delay_zero;
    logic       arm_full;
    logic       arm_zero;
    logic       count_en;
    logic [2:0] drv_status;

    always_comb begin
        st_d      = st_q;
        cmd       = pick_cmd(stop_cmd, pause_cmd, play_cmd, ffwd_cmd, frev_cmd);
        idle_tick = sector_tick && (cmd == CMD_NONE);
        arm_full  = (cmd == CMD_PLAY) && (st_q.mode == MODE_STOP || st_q.mode == MODE_PAUSE);
        arm_zero  = (cmd == CMD_PLAY) && !arm_full;
        count_en  = idle_tick && (st_q.mode == MODE_READ);
        deliver   = count_en && delay_zero;
        st_d.ready = deliver;
        if (deliver) st_d.count = st_q.count + 1'b1;
        if (count_en) st_d.data = track_is_data;
        unique case (cmd)
            CMD_STOP:  st_d.mode = MODE_STOP;
            CMD_PAUSE: st_d.mode = MODE_PAUSE;
            CMD_PLAY:  st_d.mode = MODE_READ;
            CMD_FFWD:  st_d.mode = MODE_FFWD;
            CMD_FREV:  st_d.mode = MODE_FREV;
            default:   st_d.mode = st_q.mode;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_STOP, data: 1'b0, count: '0, ready: 1'b0};
        else        st_q <= st_d;
    end

    cdseq_delay #(
        .PLAY_DELAY (PLAY_DELAY),
        .DELAY_W    (DELAY_W)
    ) i_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_full (arm_full),
        .load_zero (arm_zero),
        .count_en  (count_en),
        .is_zero   (delay_zero)
    );

    cdseq_lba #(
        .LBA_W       (LBA_W),
        .SCAN_STRIDE (SCAN_STRIDE),
        .LBA_FLOOR   (LBA_FLOOR)
    ) i_lba (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd == CMD_PLAY),
        .target   (target_lba),
        .inc_one  (deliver),
        .step_fwd (idle_tick && st_q.mode == MODE_FFWD),
        .step_rev (idle_tick && st_q.mode == MODE_FREV),
        .lba      (cur_lba)
    );

    cdseq_irq i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sector_tick),
        .cmd_done   (drive_cmd_done),
        .drv_en     (irq_enable[DRV_IRQ_EN_BIT]),
        .dec_fire   (deliver && irq_enable[DEC_IRQ_EN_BIT]),
        .mode_now   (st_q.mode),
        .drive_irq  (drive_irq),
        .dec_irq    (decoder_irq),
        .drv_status (drv_status)
    );

    assign sector_ready = st_q.ready;
    assign status_word  = {7'd0, st_q.data, st_q.count, 1'b0, drv_status};

    // R1: without tick or command the address stays put
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!sector_tick && cmd == CMD_NONE) |=> $stable(cur_lba));

    // R4: no sector while the seek delay is still running
    a_r4_hold_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_tick && st_q.mode == MODE_READ && !delay_zero) |=> !sector_ready);

    // R10: outside read mode no sector is delivered
    a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_READ) |=> !sector_ready);

    // R5: a delivered sector advances the address by one
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> (cur_lba == $past(cur_lba) + 1'b1));

endmodule

// File: tb/test_cd_sector_sequencer.sv
module test_cd_sector_sequencer;

    localparam int LBA_W  = 20;
    localparam int PDLY   = 6;
    localparam int STRIDE = 10;
    localparam int FLOOR  = -150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sector_tick = 1'b0;
    logic play_cmd = 1'b0, pause_cmd = 1'b0, stop_cmd = 1'b0, ffwd_cmd = 1'b0, frev_cmd = 1'b0;
    logic drive_cmd_done = 1'b0;
    logic [LBA_W-1:0] target_lba = '0;
    logic track_is_data = 1'b0;
    logic [7:0] irq_enable = 8'h00;
    logic [LBA_W-1:0] cur_lba;
    logic sector_ready;
    logic [15:0] status_word;
    logic drive_irq, decoder_irq;

    always #2 clk = ~clk;

    cd_sector_sequencer #(
        .LBA_W(LBA_W), .PLAY_DELAY(PDLY), .SCAN_STRIDE(STRIDE), .LBA_FLOOR(FLOOR), .CNT_W(4)
    ) i_cd_sector_sequencer (
        .clk(clk), .rst_n(rst_n), .sector_tick(sector_tick),
        .play_cmd(play_cmd), .pause_cmd(pause_cmd), .stop_cmd(stop_cmd),
        .ffwd_cmd(ffwd_cmd), .frev_cmd(frev_cmd), .drive_cmd_done(drive_cmd_done),
        .target_lba(target_lba), .track_is_data(track_is_data), .irq_enable(irq_enable),
        .cur_lba(cur_lba), .sector_ready(sector_ready), .status_word(status_word),
        .drive_irq(drive_irq), .decoder_irq(decoder_irq)
    );

    int checks = 0;
    int errors = 0;
    string phase = "R12";

    // behavioural reference: mode 0 stop,1 pause,2 read,3 ffwd,4 frev
    int m_mode, m_delay, m_lba, m_cnt, m_stat;
    bit m_data, m_pend, m_slip, m_ready, m_drq, m_dcq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_delay = 0; m_lba = 0; m_cnt = 0; m_stat = 0;
            m_data = 0; m_pend = 0; m_slip = 0; m_ready = 0; m_drq = 0; m_dcq = 0;
        end else begin
            int old_mode;
            bit old_pend, any_cmd;
            old_mode = m_mode;
            old_pend = m_pend;
            m_ready = 0; m_dcq = 0;
            m_drq = m_slip; m_slip = 0;
            any_cmd = stop_cmd | pause_cmd | play_cmd | ffwd_cmd | frev_cmd;
            if (stop_cmd) m_mode = 0;
            else if (pause_cmd) m_mode = 1;
            else if (play_cmd) begin
                m_lba = $signed(target_lba);
                m_delay = (old_mode <= 1) ? PDLY : 0;
                m_mode = 2;
            end
            else if (ffwd_cmd) m_mode = 3;
            else if (frev_cmd) m_mode = 4;
            if (sector_tick && !any_cmd) begin
                if (old_mode == 2) begin
                    m_data = track_is_data;
                    if (m_delay == 0) begin
                        m_lba++; m_cnt = (m_cnt + 1) % 16; m_ready = 1;
                        m_dcq = irq_enable[5];
                    end else m_delay--;
                end else if (old_mode == 3) m_lba += STRIDE;
                else if (old_mode == 4) m_lba = (m_lba - STRIDE < FLOOR) ? FLOOR : m_lba - STRIDE;
            end
            if (sector_tick && old_pend) begin
                m_pend = 0;
                m_stat = old_mode;
                if (irq_enable[4]) begin
                    if (m_dcq) m_slip = 1; else m_drq = 1;
                end
            end
            if (drive_cmd_done) m_pend = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [15:0] exp_stat;
            exp_stat = {7'd0, m_data, 4'(m_cnt), 1'b0, 3'(m_stat)};
            checks++;
            if ($signed(cur_lba) != m_lba || sector_ready != m_ready || status_word != exp_stat ||
                drive_irq != m_drq || decoder_irq != m_dcq) begin
                errors++;
                $display("FAIL %s: lba %0d rdy %b st %h dirq %b cirq %b | exp lba %0d rdy %b st %h dirq %b cirq %b",
                         phase, $signed(cur_lba), sector_ready, status_word, drive_irq, decoder_irq,
                         m_lba, m_ready, exp_stat, m_drq, m_dcq);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int gap = 3);
        @(negedge clk) sector_tick = 1'b1;
        @(negedge clk) sector_tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic pulse_cmd(input int which, input int tgt = 0);
        @(negedge clk);
        target_lba = LBA_W'(tgt);
        case (which)
            0: stop_cmd = 1'b1;
            1: pause_cmd = 1'b1;
            2: play_cmd = 1'b1;
            3: ffwd_cmd = 1'b1;
            default: frev_cmd = 1'b1;
        endcase
        @(negedge clk);
        {stop_cmd, pause_cmd, play_cmd, ffwd_cmd, frev_cmd} = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic mark_done();
        @(negedge clk) drive_cmd_done = 1'b1;
        @(negedge clk) drive_cmd_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 lba", $signed(cur_lba), 0);
        check("R12 status", int'(status_word), 0);
        check("R12 strobes", int'({sector_ready, drive_irq, decoder_irq}), 0);
        rst_n = 1'b1;
        irq_enable = 8'h30;
        repeat (2) @(negedge clk);

        phase = "R2";
        mark_done();
        @(negedge clk) sector_tick = 1'b1;
        @(negedge clk) sector_tick = 1'b0;
        check("R2 drive_irq", int'(drive_irq), 1);
        check("R2 mode code", int'(status_word[2:0]), 0);
        repeat (2) @(negedge clk);

        phase = "R3/R4";
        track_is_data = 1'b1;
        pulse_cmd(2, 100);
        for (int k = 0; k < PDLY; k++) begin
            tick();
            check("R4 no delivery during delay", $signed(cur_lba), 100);
        end
        phase = "R5";
        @(negedge clk) sector_tick = 1'b1;
        @(negedge clk) sector_tick = 1'b0;
        check("R5 ready", int'(sector_ready), 1);
        check("R5 decoder_irq", int'(decoder_irq), 1);
        check("R5 lba", $signed(cur_lba), 101);
        check("R8 data bit", int'(status_word[8]), 1);
        repeat (3) tick();
        check("R5 count", int'(status_word[7:4]), 4);

        phase = "R1";
        repeat (20) @(negedge clk);
        check("R1 quiet lba", $signed(cur_lba), 104);

        phase = "R8";
        track_is_data = 1'b0;
        tick();
        check("R8 audio bit", int'(status_word[8]), 0);

        phase = "R9";
        mark_done();
        @(negedge clk) sector_tick = 1'b1;
        @(negedge clk) sector_tick = 1'b0;
        check("R9 decoder first", int'({decoder_irq, drive_irq}), 2);
        @(negedge clk);
        check("R9 drive next", int'({decoder_irq, drive_irq}), 1);
        check("R2 read code", int'(status_word[2:0]), 2);
        repeat (2) @(negedge clk);

        phase = "R3";
        pulse_cmd(2, 500);
        tick();
        check("R3 no delay from read", $signed(cur_lba), 501);

        phase = "R6";
        pulse_cmd(3);
        repeat (3) tick();
        check("R6 ffwd", $signed(cur_lba), 531);
        pulse_cmd(2, 5);
        phase = "R7";
        pulse_cmd(4);
        repeat (17) tick();
        check("R7 floor", $signed(cur_lba), FLOOR);

        phase = "R10";
        pulse_cmd(2, 40);
        pulse_cmd(1);
        repeat (4) tick();
        check("R10 paused lba", $signed(cur_lba), 40);
        pulse_cmd(2, 60);
        repeat (PDLY) tick();
        check("R3 delay from pause", $signed(cur_lba), 60);
        tick();
        check("R3 after delay", $signed(cur_lba), 61);

        phase = "R11";
        @(negedge clk) begin stop_cmd = 1'b1; play_cmd = 1'b1; sector_tick = 1'b1; target_lba = 20'd900; end
        @(negedge clk) begin stop_cmd = 1'b0; play_cmd = 1'b0; sector_tick = 1'b0; end
        check("R11 stop wins and tick ignored", $signed(cur_lba), 61);
        mark_done();
        tick();
        check("R11 stop code", int'(status_word[2:0]), 0);

        phase = "R5";
        irq_enable = 8'h00;
        pulse_cmd(2, 7);
        repeat (PDLY + 12) tick(1);
        check("R5 wrapped count", int'(status_word[7:4]), (4 + 1 + 1 + 1 + 1 + 12) % 16);

        repeat (4) @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule